// File: doc/BRIEF.md
# Soft-Start and Fault Shutdown Sequencer

This block holds a digital soft-start level that bounds the duty command handed to a phase-shift bridge PWM stage. It also decides when the bridge outputs may switch. An up/down counter stands in for the charge on a timing capacitor. Each clock, the counter climbs by a small step during start-up or falls by a larger step during a soft stop. Supply and reference faults clear it to zero in the same cycle they are seen.

Three kinds of fault are handled in three ways:
- An undervoltage or a lost reference empties the level at once.
- An overcurrent starts a soft stop: a fast ramp-down, followed by a full restart from wherever the level lands.
- An external disable request parks the sequencer with the level at zero for as long as the request is held.

The supply input is a digitised voltage word. Hysteresis between a start threshold and a stop threshold decides undervoltage lockout. The current-sense word is compared against an overcurrent limit.

Top module: `softstart_seq`

## Requirements
- R1: While reset is asserted, and right after it, seq_state is 0 (UVLO), ss_level is 0 and out_en is 0.
- R2: The sequencer leaves UVLO only after supply has risen strictly above SUP_START (110). Once it has started, a supply between SUP_STOP (90) and SUP_START keeps it running. A supply strictly below SUP_STOP brings it back to UVLO on the following cycle.
- R3: While the supply is in lockout, the state goes to UVLO (code 0) and the level to 0 on the next clock, whatever the other inputs are. When the supply is good but ref_good is low, the state goes to DISABLED (code 1) and the level to 0 on the next clock.
- R4: With the supply good, dis_req high moves the sequencer to DISABLED and clears the level on the next clock. It stays there with the level at 0 while the request is held. Once the request drops, the next clock enters SOFT_START (code 2) from level 0.
- R5: In SOFT_START with no fault, the level rises by STEP_UP (8) per clock. It saturates at LVL_MAX (4000), and on the clock that reaches LVL_MAX the state becomes RUN (code 3).
- R6: A cs_word at or above OC_LIMIT (250) in SOFT_START or RUN moves the sequencer to SOFT_STOP (code 4), with the level unchanged. In SOFT_STOP the level falls by STEP_UP*DN_RATIO (80) per clock, and it does not go below 0.
- R7: The soft-stop clock that brings the level below OFF_LEVEL (400) enters SOFT_START. The ramp-up then continues from that level.
- R8: An overcurrent during SOFT_STOP has no effect. The ramp-down rate and the exit point stay the same.
- R9: out_en is 1 exactly when ss_level is at or above OFF_LEVEL.
- R10: In RUN, duty_cmd equals duty_req. In every other state, duty_cmd is the smaller of duty_req and ss_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply | input | SUP_W | Digitised supply voltage |
| ref_good | input | 1 | Reference voltage is within range |
| dis_req | input | 1 | External request to disable the outputs |
| cs_word | input | CS_W | Digitised current-sense value |
| duty_req | input | LVL_W | Duty command from the control loop |
| duty_cmd | output | LVL_W | Duty command after the soft-start clamp |
| ss_level | output | LVL_W | Present soft-start level |
| out_en | output | 1 | Bridge outputs may switch |
| seq_state | output | 3 | 0 UVLO, 1 DISABLED, 2 SOFT_START, 3 RUN, 4 SOFT_STOP |

## Verification
The bench goes after four corner cases.
- Supply in the hysteresis band: a design without hysteresis would either refuse to start at 100 or drop out when the supply sags to 100.
- Soft-stop exit: the level sits exactly at the off threshold for one clock and only crosses it on the next step. An off-by-one comparison would restart one clock early and raise out_en wrongly.
- Overcurrent held through a soft stop: a design that does not ignore it would freeze or re-enter the stop.
- Undervoltage arriving during a disable or a reference loss: wrong priority would leave the state at DISABLED instead of UVLO.

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int SUP_W     = 8,
  parameter int CS_W      = 8,
  parameter int LVL_W     = 12,
  parameter int SUP_START = 110,
  parameter int SUP_STOP  = 90,
  parameter int OC_LIMIT  = 250,
  parameter int LVL_MAX   = 4000,
  parameter int OFF_LEVEL = 400,
  parameter int STEP_UP   = 8,
  parameter int DN_RATIO  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply,
  input  logic             ref_good,
  input  logic             dis_req,
  input  logic [CS_W-1:0]  cs_word,
  input  logic [LVL_W-1:0] duty_req,
  output logic [LVL_W-1:0] duty_cmd,
  output logic [LVL_W-1:0] ss_level,
  output logic             out_en,
  output logic [2:0]       seq_state
);

  localparam int STEP_DN = STEP_UP * DN_RATIO;
  localparam logic [SUP_W-1:0] START_V = SUP_W'(SUP_START);
  localparam logic [SUP_W-1:0] STOP_V  = SUP_W'(SUP_STOP);
  localparam logic [CS_W-1:0]  OC_V    = CS_W'(OC_LIMIT);
  localparam logic [LVL_W-1:0] LMAX    = LVL_W'(LVL_MAX);
  localparam logic [LVL_W-1:0] OFF_V   = LVL_W'(OFF_LEVEL);
  localparam logic [LVL_W-1:0] DN_V    = LVL_W'(STEP_DN);
  localparam logic [LVL_W:0]   UP_X    = (LVL_W+1)'(STEP_UP);
  localparam logic [LVL_W:0]   LMAX_X  = (LVL_W+1)'(LVL_MAX);

  typedef enum logic [2:0] {
    S_UVLO = 3'd0,
    S_DIS  = 3'd1,
    S_SS   = 3'd2,
    S_RUN  = 3'd3,
    S_STOP = 3'd4
  } seq_e;

  seq_e             st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             sup_ok_q;
  logic             oc;
  logic [LVL_W:0]   up_sum;
  logic [LVL_W-1:0] dn_val;

  assign oc     = cs_word >= OC_V;
  assign up_sum = {1'b0, lvl_q} + UP_X;
  assign dn_val = (lvl_q > DN_V) ? lvl_q - DN_V : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         sup_ok_q <= 1'b0;
    else if (!sup_ok_q && supply > START_V) sup_ok_q <= 1'b1;
    else if (sup_ok_q && supply < STOP_V)   sup_ok_q <= 1'b0;
  end

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    if (!sup_ok_q) begin
      st_d  = S_UVLO;
      lvl_d = '0;
    end else if (!ref_good || dis_req) begin
      st_d  = S_DIS;
      lvl_d = '0;
    end else begin
      case (st_q)
        S_UVLO, S_DIS: st_d = S_SS;
        S_SS: begin
          if (oc) st_d = S_STOP;
          else if (up_sum >= LMAX_X) begin
            lvl_d = LMAX;
            st_d  = S_RUN;
          end else lvl_d = up_sum[LVL_W-1:0];
        end
        S_RUN: if (oc) st_d = S_STOP;
        S_STOP: begin
          lvl_d = dn_val;
          if (dn_val < OFF_V) st_d = S_SS;
        end
        default: begin
          st_d  = S_UVLO;
          lvl_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_UVLO;
      lvl_q <= '0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign ss_level  = lvl_q;
  assign seq_state = st_q;
  assign out_en    = lvl_q >= OFF_V;
  assign duty_cmd  = (st_q == S_RUN || duty_req < lvl_q) ? duty_req : lvl_q;

  AST_UV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok_q |=> (seq_state == 3'd0 && ss_level == '0)); // R3
  AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ok_q && (!ref_good || dis_req)) |=> (seq_state == 3'd1 && ss_level == '0)); // R4
  AST_RAMP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SS && sup_ok_q && ref_good && !dis_req && !oc)
      |=> (int'(ss_level) == int'($past(ss_level)) + STEP_UP || ss_level == LMAX)); // R5
  AST_LVL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ss_level <= LMAX); // R5
  AST_STOP_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STOP && sup_ok_q && ref_good && !dis_req)
      |=> (int'(ss_level) + STEP_DN == int'($past(ss_level)) || ss_level == '0)); // R6
  AST_OC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STOP && sup_ok_q && ref_good && !dis_req)
      |=> (seq_state == 3'd4 || seq_state == 3'd2)); // R8
  AST_OFF_WHEN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd0 || seq_state == 3'd1) |-> !out_en); // R9
  AST_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 3'd3) |-> (duty_cmd <= ss_level && duty_cmd <= duty_req)); // R10

endmodule

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  supply = 8'd0;
  logic        ref_good = 1'b1;
  logic        dis_req = 1'b0;
  logic [7:0]  cs_word = 8'd0;
  logic [11:0] duty_req = 12'd0;
  logic [11:0] duty_cmd, ss_level;
  logic        out_en;
  logic [2:0]  seq_state;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  softstart_seq dut (
    .clk(clk), .rst_n(rst_n), .supply(supply), .ref_good(ref_good),
    .dis_req(dis_req), .cs_word(cs_word), .duty_req(duty_req),
    .duty_cmd(duty_cmd), .ss_level(ss_level), .out_en(out_en),
    .seq_state(seq_state)
  );

  typedef struct packed {
    logic [7:0]  sup;
    logic        rg;
    logic        dis;
    logic [7:0]  cs;
    logic [11:0] duty;
    logic [15:0] cyc;
    logic [2:0]  st;
    logic [11:0] lvl;
    logic        en;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{100, 1, 0, 0,   3000, 5,   0, 0,    0},
    '{111, 1, 0, 0,   3000, 1,   0, 0,    0},
    '{111, 1, 0, 0,   3000, 1,   2, 0,    0},
    '{111, 1, 0, 0,   100,  49,  2, 392,  0},
    '{111, 1, 0, 0,   3000, 1,   2, 400,  1},
    '{100, 1, 0, 0,   3000, 10,  2, 480,  1},
    '{100, 1, 0, 0,   3000, 440, 3, 4000, 1},
    '{100, 1, 0, 0,   4095, 5,   3, 4000, 1},
    '{100, 1, 0, 250, 3000, 1,   4, 4000, 1},
    '{100, 1, 0, 255, 3000, 10,  4, 3200, 1},
    '{100, 1, 0, 0,   3000, 35,  4, 400,  1},
    '{100, 1, 0, 0,   3000, 1,   2, 320,  0},
    '{100, 1, 0, 0,   3000, 10,  2, 400,  1},
    '{100, 1, 1, 0,   3000, 1,   1, 0,    0},
    '{100, 1, 1, 0,   3000, 20,  1, 0,    0},
    '{100, 1, 0, 0,   3000, 1,   2, 0,    0},
    '{100, 1, 0, 0,   3000, 5,   2, 40,   0},
    '{100, 0, 0, 0,   3000, 1,   1, 0,    0},
    '{80,  0, 0, 0,   3000, 1,   1, 0,    0},
    '{80,  0, 0, 0,   3000, 1,   0, 0,    0},
    '{100, 1, 0, 0,   3000, 3,   0, 0,    0},
    '{120, 1, 0, 0,   3000, 2,   2, 0,    0},
    '{120, 1, 0, 0,   3000, 10,  2, 80,   0},
    '{50,  1, 1, 0,   3000, 1,   1, 0,    0},
    '{50,  1, 1, 0,   3000, 1,   0, 0,    0},
    '{120, 1, 0, 0,   3000, 2,   2, 0,    0},
    '{120, 1, 0, 0,   3000, 100, 2, 800,  1},
    '{85,  1, 0, 0,   3000, 1,   2, 808,  1},
    '{85,  1, 0, 0,   3000, 1,   0, 0,    0}
  };

  localparam string TAG [NV] = '{
    "R2", "R2", "R2", "R9", "R9", "R2", "R5", "R5", "R6", "R8",
    "R7", "R7", "R7", "R4", "R4", "R4", "R4", "R3", "R3", "R3",
    "R2", "R2", "R2", "R3", "R3", "R3", "R3", "R3", "R3"
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic see(input string tag, input int st, input int lvl, input int en);
    chk(tag, "state", int'(seq_state), st);
    chk(tag, "level", int'(ss_level), lvl);
    chk(tag, "out_en", int'(out_en), en);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(2);
    see("R1", 0, 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      supply   = TBL[i].sup;
      ref_good = TBL[i].rg;
      dis_req  = TBL[i].dis;
      cs_word  = TBL[i].cs;
      duty_req = TBL[i].duty;
      run(int'(TBL[i].cyc));
      see(TAG[i], int'(TBL[i].st), int'(TBL[i].lvl), int'(TBL[i].en));
      chk("R10", "duty_cmd", int'(duty_cmd),
          (TBL[i].st == 3'd3 || TBL[i].duty < TBL[i].lvl) ? int'(TBL[i].duty) : int'(TBL[i].lvl));
    end

    // reset in the middle of a ramp
    supply = 8'd120; dis_req = 1'b0; ref_good = 1'b1; cs_word = 8'd0;
    run(32);
    see("R5", 2, 240, 0);
    rst_n = 1'b0;
    run(1);
    see("R1", 0, 0, 0);
    rst_n = 1'b1;
    run(2);
    see("R2", 2, 0, 0);
    // overcurrent at level zero: stop then immediate restart
    cs_word = 8'd250;
    run(1);
    see("R6", 4, 0, 0);
    run(1);
    see("R7", 2, 0, 0);
    cs_word = 8'd0;
    run(3);
    see("R5", 2, 24, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule